// File: doc/BRIEF.md
# Plane Depth Divider

This block turns the transformed coefficients of one plane into a screen depth and its per-pixel steps. It computes Z = D/(-C), dZx = A·dX/(-C) and dZy = B·dY/(-C) without a divider circuit. The magnitude of C is first normalised to a fraction in [0.5, 1), and the shift count is recorded. The three numerators and the normalised divisor are then all multiplied by (2 - divisor) over a fixed number of rounds. Each round squares the divisor's distance from one, so after the last round the divisor is taken as 1.0 and each numerator is read as its quotient. The recorded shift is then applied back to the numerators.

The undivided values K = D, dKx = A·dX and dKy = B·dY travel beside the quotients. When the plane is nearly edge-on to the screen, a depth step grows past one whole unit per pixel. In that case, and whenever C is zero, the block outputs the K values instead of the Z values and raises a flag. Operands enter through a valid/ready handshake and leave one cycle per multiply round plus one normalisation cycle later. The pipeline stalls as a whole when the consumer holds off.

Top module: `plane_depth_div`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: When out_perp is 0, out_z equals D/(-C) within 2 LSB. All values are signed two's complement with 16 fractional bits (1.0 = 65536).
- R3: When out_perp is 0, out_dzx equals dKx/(-C) and out_dzy equals dKy/(-C) within 2 LSB. Here dKx = floor(A·dX / 65536) and dKy = floor(B·dY / 65536).
- R4: Accuracy holds for either sign of C and for |C| from below 0.01 to above 300. The sign of every quotient follows the sign of -C.
- R5: If |dKx| > |C| or |dKy| > |C| (a depth step above 1.0), out_perp is 1 and the outputs are out_z = D, out_dzx = dKx and out_dzy = dKy exactly. A step of exactly 1.0 does not set the flag.
- R6: C = 0 gives out_perp = 1 and the three K values, with no iteration applied.
- R7: With out_ready held at 1, a result appears ROUNDS+1 clock edges after its operands are accepted (6 by default), and one operand set is accepted on every cycle.
- R8: While out_valid is 1 and out_ready is 0, all outputs hold steady, in_ready is 0, and no result is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set |
| coef_a | input | W | Plane coefficient A, signed fixed point |
| coef_b | input | W | Plane coefficient B |
| coef_c | input | W | Plane coefficient C (the divisor, negated) |
| coef_d | input | W | Plane coefficient D |
| step_x | input | W | Pixel spacing in X |
| step_y | input | W | Pixel spacing in Y |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_z | output | W | Depth Z, or K when flagged |
| out_dzx | output | W | X step of Z, or dKx when flagged |
| out_dzy | output | W | Y step of Z, or dKy when flagged |
| out_perp | output | 1 | Near-perpendicular plane, K values selected |

## Verification
The edge-on fallback and the consumer stall can act on the same result. The bench makes this happen by sending flagged planes and C = 0 planes in a back-to-back stream while out_ready is toggled pseudo-randomly. So a K-selected result often sits at the output through several held cycles while new operands wait at the input. Each result is judged on exact K equality with the flag set, and also on in-order, single delivery through the scoreboard. A boundary plane, whose step is exactly 1.0, shows that the divided path stays selected at the threshold.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  // Default operand format shared by the stages.
  localparam int PDD_W_DEF = 32;
  localparam int PDD_F_DEF = 16;
  localparam int PDD_G_DEF = 16;
  localparam int PDD_ROUNDS_DEF = 5;
  localparam int PDD_EW = 8;  // width of the recorded normalisation shift

  // Index of the highest set bit, 0 for a zero input.
  function automatic int unsigned pdd_msb_index(input logic [63:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/pdd_norm.sv
module pdd_norm
  import pdd_pkg::*;
#(
  parameter int W = PDD_W_DEF,
  parameter int F = PDD_F_DEF,
  parameter int G = PDD_G_DEF,
  localparam int IF = W + G,
  localparam int NW = W + G + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   in_valid,
  input  logic [W-1:0]           a,
  input  logic [W-1:0]           b,
  input  logic [W-1:0]           c,
  input  logic [W-1:0]           d,
  input  logic [W-1:0]           dx,
  input  logic [W-1:0]           dy,
  output logic                   v_q,
  output logic                   cz_q,
  output logic signed [PDD_EW-1:0] e_q,
  output logic [IF:0]            n_q,
  output logic [2:0][NW-1:0]     num_q,
  output logic [2:0][W-1:0]      k_q
);
  // Fixed-point product with F fractional bits kept.
  function automatic logic [W-1:0] fx_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [2*W-1:0] pr;
    pr = $signed(x) * $signed(y);
    return W'(pr >>> F);
  endfunction

  // Numerator widened by G guard bits, negated when C is positive.
  function automatic logic [NW-1:0] fx_widen(input logic [W-1:0] x, input logic flip);
    logic signed [NW-1:0] xs;
    xs = NW'($signed(x));
    xs = xs <<< G;
    if (flip) xs = -xs;
    return xs;
  endfunction

  logic [W-1:0]        mag;
  int unsigned         top;
  logic [IF-1:0]       frac;
  logic [2:0][W-1:0]   kv;
  logic [2:0][NW-1:0]  nv;
  logic                flip;

  always_comb begin
    mag  = c[W-1] ? (~c + 1'b1) : c;
    top  = pdd_msb_index(64'(mag));
    frac = {mag, {G{1'b0}}} << (W - 1 - top);
    flip = ~c[W-1];
    kv[0] = d;
    kv[1] = fx_mul(a, dx);
    kv[2] = fx_mul(b, dy);
    for (int i = 0; i < 3; i++) nv[i] = fx_widen(kv[i], flip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else if (adv) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      cz_q  <= (c == '0);
      e_q   <= PDD_EW'(F - 1 - int'(top));
      n_q   <= {1'b0, frac};
      num_q <= nv;
      k_q   <= kv;
    end
  end
endmodule

// File: rtl/pdd_round.sv
module pdd_round
  import pdd_pkg::*;
#(
  parameter int W = PDD_W_DEF,
  parameter int G = PDD_G_DEF,
  localparam int IF = W + G,
  localparam int NW = W + G + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     i_v,
  input  logic                     i_cz,
  input  logic signed [PDD_EW-1:0] i_e,
  input  logic [IF:0]              i_n,
  input  logic [2:0][NW-1:0]       i_num,
  input  logic [2:0][W-1:0]        i_k,
  output logic                     o_v,
  output logic                     o_cz,
  output logic signed [PDD_EW-1:0] o_e,
  output logic [IF:0]              o_n,
  output logic [2:0][NW-1:0]       o_num,
  output logic [2:0][W-1:0]        o_k
);
  // Divisor times the correction factor, IF fractional bits kept.
  function automatic logic [IF:0] gs_div(input logic [IF:0] n, input logic [IF+1:0] r);
    logic [2*IF+2:0] nr;
    nr = n * r;
    return (IF+1)'(nr >> IF);
  endfunction

  // Signed numerator times the correction factor.
  function automatic logic [NW-1:0] gs_num(input logic [NW-1:0] x, input logic [IF+1:0] r);
    logic signed [NW+IF+2:0] pr;
    pr = $signed(x) * $signed({1'b0, r});
    return NW'(pr >>> IF);
  endfunction

  logic [IF+1:0]      fac;
  logic [IF:0]        n_nx;
  logic [2:0][NW-1:0] num_nx;

  always_comb begin
    fac  = {2'b10, {IF{1'b0}}} - {1'b0, i_n};
    n_nx = i_cz ? i_n : gs_div(i_n, fac);
    for (int i = 0; i < 3; i++) num_nx[i] = i_cz ? i_num[i] : gs_num(i_num[i], fac);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_v <= 1'b0;
    else if (adv) o_v <= i_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      o_cz  <= i_cz;
      o_e   <= i_e;
      o_n   <= n_nx;
      o_num <= num_nx;
      o_k   <= i_k;
    end
  end
endmodule

// File: rtl/pdd_finish.sv
module pdd_finish
  import pdd_pkg::*;
#(
  parameter int W = PDD_W_DEF,
  parameter int F = PDD_F_DEF,
  parameter int G = PDD_G_DEF,
  localparam int NW = W + G + 2,
  localparam int XW = NW + F
) (
  input  logic                     cz,
  input  logic signed [PDD_EW-1:0] e,
  input  logic [2:0][NW-1:0]       num,
  input  logic [2:0][W-1:0]        k,
  output logic [W-1:0]             z,
  output logic [W-1:0]             dzx,
  output logic [W-1:0]             dzy,
  output logic                     perp
);
  localparam logic signed [XW-1:0] XMAX = XW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [XW-1:0] XMIN = -XMAX - XW'(1);
  localparam logic signed [W:0]    ONE  = (W+1)'(64'sd1 <<< F);

  // Apply the normalisation shift, drop guard bits, saturate to W bits.
  function automatic logic [W-1:0] fx_denorm(input logic [NW-1:0] nm,
                                             input logic signed [PDD_EW-1:0] ex);
    logic signed [XW-1:0] x;
    x = XW'($signed(nm));
    if (ex >= 0) x = x <<< ex;
    else         x = x >>> (-ex);
    x = x >>> G;
    if (x > XMAX)      return W'(XMAX);
    else if (x < XMIN) return W'(XMIN);
    return W'(x);
  endfunction

  // Magnitude strictly above 1.0.
  function automatic logic fx_over_one(input logic [W-1:0] v);
    logic signed [W:0] s;
    s = $signed({v[W-1], v});
    if (s < 0) s = -s;
    return s > ONE;
  endfunction

  logic [W-1:0] q0, q1, q2;

  always_comb begin
    q0   = fx_denorm(num[0], e);
    q1   = fx_denorm(num[1], e);
    q2   = fx_denorm(num[2], e);
    perp = cz | fx_over_one(q1) | fx_over_one(q2);
    z    = perp ? k[0] : q0;
    dzx  = perp ? k[1] : q1;
    dzy  = perp ? k[2] : q2;
  end
endmodule

// File: rtl/plane_depth_div.sv
module plane_depth_div
  import pdd_pkg::*;
#(
  parameter int W = PDD_W_DEF,
  parameter int F = PDD_F_DEF,
  parameter int G = PDD_G_DEF,
  parameter int ROUNDS = PDD_ROUNDS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] coef_a,
  input  logic [W-1:0] coef_b,
  input  logic [W-1:0] coef_c,
  input  logic [W-1:0] coef_d,
  input  logic [W-1:0] step_x,
  input  logic [W-1:0] step_y,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_z,
  output logic [W-1:0] out_dzx,
  output logic [W-1:0] out_dzy,
  output logic         out_perp
);
  localparam int IF = W + G;
  localparam int NW = W + G + 2;

  logic                     adv;
  logic                     s_v   [ROUNDS+1];
  logic                     s_cz  [ROUNDS+1];
  logic signed [PDD_EW-1:0] s_e   [ROUNDS+1];
  logic [IF:0]              s_n   [ROUNDS+1];
  logic [2:0][NW-1:0]       s_num [ROUNDS+1];
  logic [2:0][W-1:0]        s_k   [ROUNDS+1];

  // Named views for the checker.
  logic        norm_v, norm_cz, last_cz;
  logic [IF:0] norm_n, last_n;

  assign adv       = ~out_valid | out_ready;
  assign in_ready  = adv;
  assign out_valid = s_v[ROUNDS];
  assign norm_v    = s_v[0];
  assign norm_cz   = s_cz[0];
  assign norm_n    = s_n[0];
  assign last_cz   = s_cz[ROUNDS];
  assign last_n    = s_n[ROUNDS];

  pdd_norm #(.W(W), .F(F), .G(G)) u_norm (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(in_valid),
    .a(coef_a), .b(coef_b), .c(coef_c), .d(coef_d), .dx(step_x), .dy(step_y),
    .v_q(s_v[0]), .cz_q(s_cz[0]), .e_q(s_e[0]), .n_q(s_n[0]),
    .num_q(s_num[0]), .k_q(s_k[0])
  );

  for (genvar g = 0; g < ROUNDS; g++) begin : g_round
    pdd_round #(.W(W), .G(G)) u_round (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .i_v(s_v[g]), .i_cz(s_cz[g]), .i_e(s_e[g]), .i_n(s_n[g]),
      .i_num(s_num[g]), .i_k(s_k[g]),
      .o_v(s_v[g+1]), .o_cz(s_cz[g+1]), .o_e(s_e[g+1]), .o_n(s_n[g+1]),
      .o_num(s_num[g+1]), .o_k(s_k[g+1])
    );
  end

  pdd_finish #(.W(W), .F(F), .G(G)) u_finish (
    .cz(s_cz[ROUNDS]), .e(s_e[ROUNDS]), .num(s_num[ROUNDS]), .k(s_k[ROUNDS]),
    .z(out_z), .dzx(out_dzx), .dzy(out_dzy), .perp(out_perp)
  );
endmodule

// File: rtl/pdd_chk.sv
module pdd_chk #(
  parameter int W = 32,
  parameter int F = 16,
  parameter int IF = 48
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_z,
  input logic [W-1:0] out_dzx,
  input logic [W-1:0] out_dzy,
  input logic         out_perp,
  input logic         norm_v,
  input logic         norm_cz,
  input logic [IF:0]  norm_n,
  input logic         last_cz,
  input logic [IF:0]  last_n
);
  localparam logic signed [W:0] ONE = (W+1)'(64'sd1 <<< F);
  logic signed [W:0] ax, ay;
  assign ax = out_dzx[W-1] ? -$signed({1'b1, out_dzx}) : $signed({1'b0, out_dzx});
  assign ay = out_dzy[W-1] ? -$signed({1'b1, out_dzy}) : $signed({1'b0, out_dzy});

  // R4: normalised divisor lies in [0.5, 1)
  a_r4_norm_range: assert property (@(posedge clk) disable iff (!rst_n)
    norm_v && !norm_cz |-> norm_n[IF-1] && !norm_n[IF]);

  // R2: after the rounds the divisor sits just below 1.0
  a_r2_converged: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !last_cz |-> !last_n[IF] && (&last_n[IF-1 -: 12]));

  // R6: a zero divisor always selects the undivided values
  a_r6_zero_selects_k: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && last_cz |-> out_perp);

  // R5: an unflagged result never carries a step above 1.0
  a_r5_steps_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_perp |-> (ax <= ONE) && (ay <= ONE));

  // R8: a held result stays put and blocks the input
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_z) && $stable(out_dzx)
      && $stable(out_dzy) && $stable(out_perp));

  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind plane_depth_div pdd_chk #(.W(W), .F(F), .IF(W + G)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_z(out_z), .out_dzx(out_dzx), .out_dzy(out_dzy),
  .out_perp(out_perp), .norm_v(norm_v), .norm_cz(norm_cz), .norm_n(norm_n),
  .last_cz(last_cz), .last_n(last_n)
);

// File: tb/plane_depth_div_bench.sv
module plane_depth_div_bench;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_perp;
  logic [31:0] ca = '0, cb = '0, cc = '0, cd = '0, sx = '0, sy = '0;
  logic [31:0] oz, odx, ody;

  always #4 clk = ~clk;  // 125 MHz

  plane_depth_div u_plane_depth_div (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .coef_a(ca), .coef_b(cb), .coef_c(cc), .coef_d(cd), .step_x(sx), .step_y(sy),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_z(oz), .out_dzx(odx), .out_dzy(ody), .out_perp(out_perp)
  );

  typedef struct {
    longint k0, k1, k2;   // undivided values
    longint e0, e1, e2;   // exact quotients, 24 fractional bits
    logic   perp;
    int     cyc;
    logic   lat;
    string  tag;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0, cyc = 0, pushed = 0, popped = 0;
  logic lat_mode = 1'b0, bp_mode = 1'b0, done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] step_lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic longint fxk(input logic [31:0] x, input logic [31:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return longint'(32'(p >>> 16));
  endfunction

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input logic [31:0] d, input logic [31:0] dx, input logic [31:0] dy,
                      input string tag);
    exp_t it;
    longint cv;
    cv = longint'($signed(c));
    it.k0 = longint'($signed(d));
    it.k1 = fxk(a, dx);
    it.k2 = fxk(b, dy);
    it.perp = (cv == 0) || (labs(it.k1) > labs(cv)) || (labs(it.k2) > labs(cv));
    it.e0 = (cv == 0) ? 0 : (it.k0 <<< 24) / (-cv);
    it.e1 = (cv == 0) ? 0 : (it.k1 <<< 24) / (-cv);
    it.e2 = (cv == 0) ? 0 : (it.k2 <<< 24) / (-cv);
    it.lat = lat_mode;
    it.tag = tag;
    @(negedge clk);
    ca = a; cb = b; cc = c; cd = d; sx = dx; sy = dy; in_valid = 1'b1;
    forever begin
      #2;
      if (in_ready) begin
        it.cyc = cyc;
        q.push_back(it);
        pushed++;
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
  endtask

  // Monitor: sets out_ready, pops and compares each delivered result.
  initial begin
    logic [15:0] bl;
    exp_t it;
    bl = 16'hACE1;
    forever begin
      @(negedge clk);
      #1;
      bl = {bl[14:0], bl[15] ^ bl[13] ^ bl[12] ^ bl[10]};
      out_ready = bp_mode ? (bl[0] | bl[3]) : 1'b1;
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected result", 1, 0);
        end else begin
          it = q.pop_front();
          popped++;
          check(out_perp == it.perp, it.tag, "perp flag", longint'(out_perp), longint'(it.perp));
          if (it.perp) begin
            check(longint'($signed(oz)) == it.k0, it.tag, "K", longint'($signed(oz)), it.k0);
            check(longint'($signed(odx)) == it.k1, it.tag, "dKx", longint'($signed(odx)), it.k1);
            check(longint'($signed(ody)) == it.k2, it.tag, "dKy", longint'($signed(ody)), it.k2);
          end else begin
            check(labs((longint'($signed(oz)) <<< 8) - it.e0) <= 512, it.tag, "Z x256",
                  longint'($signed(oz)) <<< 8, it.e0);
            check(labs((longint'($signed(odx)) <<< 8) - it.e1) <= 512, it.tag, "dZx x256 (R3)",
                  longint'($signed(odx)) <<< 8, it.e1);
            check(labs((longint'($signed(ody)) <<< 8) - it.e2) <= 512, it.tag, "dZy x256 (R3)",
                  longint'($signed(ody)) <<< 8, it.e2);
          end
          if (it.lat)
            check((cyc - it.cyc) == LAT, "R7", "latency", longint'(cyc - it.cyc), LAT);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] mg, c, d, a, b, dx, dy;
    longint kx, ky;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);

    // Directed planes, back to back, consumer always ready.
    lat_mode = 1'b1;
    send(32'sd16384, -32'sd32768, -32'sd98304, 32'sd196608, 32'sd65536, 32'sd65536, "R2");
    send(32'sd65536, 32'sd0, 32'sd131072, 32'sd327680, 32'sd32768, 32'sd65536, "R4");
    send(32'sd328, -32'sd200, 32'sd655, 32'sd3277, 32'sd65536, 32'sd65536, "R4");
    send(32'sd6553600, 32'sd65536, -32'sd19660800, 32'sd65536000, 32'sd65536, 32'sd65536, "R4");
    send(32'sd131072, 32'sd0, -32'sd32768, 32'sd65536, 32'sd65536, 32'sd65536, "R5");
    send(32'sd0, -32'sd196608, 32'sd65536, -32'sd65536, 32'sd65536, 32'sd65536, "R5");
    send(32'sd5, 32'sd7, 32'sd0, 32'sd12345, 32'sd65536, 32'sd131072, "R6");
    send(32'sd65536, 32'sd0, -32'sd65536, 32'sd65536, 32'sd65536, 32'sd65536, "R5");
    idle();
    drain();
    lat_mode = 1'b0;

    // Random stream under backpressure, mixing flagged and zero-divisor planes.
    bp_mode = 1'b1;
    for (int i = 0; i < 48; i++) begin
      lfsr = step_lfsr(lfsr); mg = (lfsr & 32'h000F_FFFF) + 32'd300;
      lfsr = step_lfsr(lfsr); c = lfsr[5] ? mg : -mg;
      if (i % 11 == 5) c = '0;
      lfsr = step_lfsr(lfsr); d = (lfsr % (mg * 8)) - mg * 4;
      lfsr = step_lfsr(lfsr); a = (lfsr % (mg * 4)) - mg * 2;
      lfsr = step_lfsr(lfsr); b = (lfsr % (mg * 4)) - mg * 2;
      dx = lfsr[9] ? 32'sd65536 : 32'sd32768;
      dy = 32'sd65536;
      kx = fxk(a, dx);
      ky = fxk(b, dy);
      if (labs(labs(kx) - longint'(mg)) < longint'(mg / 256) + 4) a = '0;
      if (labs(labs(ky) - longint'(mg)) < longint'(mg / 256) + 4) b = '0;
      send(a, b, c, d, dx, dy, (c == '0) ? "R6" : "R8");
    end
    idle();
    drain();
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    check(q.size() == 0, "R8", "results outstanding", longint'(q.size()), 0);
    check(popped == pushed, "R8", "results delivered", longint'(popped), longint'(pushed));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule